// File: doc/BRIEF.md
# Test-Bit Correlation Detector

This block decides whether a single reference (test) bit is supported by enough of a small group of sample bits. For each sample it forms an agreement bit, which is 1 when the sample equals the test bit. It then decides whether the number of agreements reaches a threshold that is chosen as a percentage of the group. Two group sizes are available. The wide group uses all five samples and offers 60%, 80% or 100% agreement. The narrow group uses only the four low samples and offers 75% or 100%.

The decision comes from a fixed-width majority voter. The agreement bits fill part of the voter's inputs. The voter's spare inputs are tied to constant ones or zeros, and the number of ones sets the effective threshold. The block also computes the agreement count separately and presents it next to the flag. Results are registered: a request presented with `in_valid` high appears on the outputs one clock later, with `out_valid` marking it. Between requests the outputs hold their last result.

Top module: `corr_detect`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `match` and `agree_cnt` are all 0.
- R2: A sample agrees when it equals `test_bit`. `agree_cnt` is the number of agreeing samples among the active ones. In wide mode the active samples are bits [4:0]; in narrow mode they are bits [3:0].
- R3: In wide mode (`use_four`=0) with `thr_code`=2'b00, `match` is 1 exactly when `agree_cnt` is at least 3.
- R4: In wide mode with `thr_code`=2'b01, `match` is 1 exactly when `agree_cnt` is at least 4.
- R5: In wide mode with `thr_code`=2'b10 or the unused code 2'b11, `match` is 1 only when all 5 samples agree.
- R6: In narrow mode (`use_four`=1) with `thr_code`=2'b00, `match` is 1 exactly when at least 3 of the 4 samples in bits [3:0] agree.
- R7: In narrow mode with `thr_code`=2'b01, 2'b10 or 2'b11, `match` is 1 only when all 4 samples in bits [3:0] agree.
- R8: In narrow mode, `samples[4]` has no effect on `match` or `agree_cnt`, and `agree_cnt` never exceeds 4.
- R9: `match` and `agree_cnt` reflect the inputs sampled at the rising edge where `in_valid` was 1. `out_valid` is 1 for exactly the cycle after each such edge.
- R10: After an edge where `in_valid` is 0, `match` and `agree_cnt` keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Present a request this cycle |
| test_bit | input | 1 | Reference bit the samples are compared against |
| samples | input | 5 | Sample bits; only [3:0] are used in narrow mode |
| use_four | input | 1 | 0 selects the wide (5-sample) group, 1 the narrow (4-sample) group |
| thr_code | input | 2 | Threshold code: 00 = low (60% or 75%), 01 = 80% wide / 100% narrow, 10 and 11 = 100% |
| out_valid | output | 1 | Registered result valid for one cycle |
| match | output | 1 | Agreement count reached the selected threshold |
| agree_cnt | output | 3 | Number of agreeing active samples |

## Verification
Each threshold is driven with agreement counts that sit exactly on the threshold and one below it. This shows whether the voter's constant padding produces the intended cut-off rather than a neighbouring one. Each case is also run with a test bit of 0 and with a test bit of 1, which separates a real agreement comparison from a plain count of ones in the samples. In narrow mode, vectors with the unused top sample set and cleared show whether that sample leaks into the count or the vote. Separate directed sequences check the one-cycle result timing, holding while idle, and the behaviour of the unused threshold code.

// File: rtl/corr_pkg.sv
package corr_pkg;

  typedef enum logic [1:0] {
    THR_LOW   = 2'b00,
    THR_MID   = 2'b01,
    THR_FULL  = 2'b10,
    THR_SPARE = 2'b11
  } thr_code_e;

  // Population count over a fixed 16-bit field; callers zero-extend.
  function automatic logic [4:0] count_ones(input logic [15:0] v);
    logic [4:0] acc;
    acc = '0;
    for (int i = 0; i < 16; i++) acc = acc + {4'd0, v[i]};
    return acc;
  endfunction

  // Smallest agreement count reaching pct percent of n samples.
  function automatic int pct_to_count(input int n, input int pct);
    return (n * pct + 99) / 100;
  endfunction

endpackage

// File: rtl/corr_agree.sv
module corr_agree #(
  parameter int N = 5
) (
  input  logic         test_bit,
  input  logic [N-1:0] samples,
  input  logic [N-1:0] active,
  output logic [N-1:0] agree
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign agree[i] = active[i] & ~(samples[i] ^ test_bit);
  end
endmodule

// File: rtl/corr_thresh.sv
module corr_thresh
  import corr_pkg::*;
#(
  parameter int N_BIG   = 5,
  parameter int N_SMALL = 4,
  parameter int CNT_W   = 3,
  parameter int SPARE_W = 4
) (
  input  logic               use_four,
  input  logic [1:0]         code,
  output logic [CNT_W-1:0]   need_k,
  output logic [SPARE_W-1:0] spare_fill
);
  localparam int K_BIG_LOW   = pct_to_count(N_BIG, 60);
  localparam int K_BIG_MID   = pct_to_count(N_BIG, 80);
  localparam int K_BIG_FULL  = N_BIG;
  localparam int K_SMALL_LOW = pct_to_count(N_SMALL, 75);
  localparam int K_SMALL_FULL = N_SMALL;

  thr_code_e c;
  int        k;
  int        ones_needed;

  assign c = thr_code_e'(code);

  always_comb begin
    if (use_four) begin
      k = (c == THR_LOW) ? K_SMALL_LOW : K_SMALL_FULL;
    end else begin
      case (c)
        THR_LOW: k = K_BIG_LOW;
        THR_MID: k = K_BIG_MID;
        default: k = K_BIG_FULL;
      endcase
    end
    // Voter of 2*N_BIG-1 inputs needs N_BIG ones; spare ones lower the bar.
    ones_needed = N_BIG - k;
  end

  assign need_k = CNT_W'(k);

  for (genvar i = 0; i < SPARE_W; i++) begin : g_fill
    assign spare_fill[i] = (i < ones_needed);
  end
endmodule

// File: rtl/corr_vote.sv
module corr_vote
  import corr_pkg::*;
#(
  parameter int W = 9
) (
  input  logic [W-1:0] votes,
  output logic         hit
);
  localparam int HALF = (W + 1) / 2;
  logic [4:0] tally;
  assign tally = count_ones(16'(votes));
  assign hit   = (tally >= 5'(HALF));
endmodule

// File: rtl/corr_detect.sv
module corr_detect
  import corr_pkg::*;
#(
  parameter int N_BIG   = 5,
  parameter int N_SMALL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             test_bit,
  input  logic [N_BIG-1:0] samples,
  input  logic             use_four,
  input  logic [1:0]       thr_code,
  output logic             out_valid,
  output logic             match,
  output logic [$clog2(N_BIG+1)-1:0] agree_cnt
);
  localparam int CNT_W   = $clog2(N_BIG + 1);
  localparam int VOTE_W  = 2 * N_BIG - 1;
  localparam int SPARE_W = VOTE_W - N_BIG;

  logic [N_BIG-1:0]   active;
  logic [N_BIG-1:0]   agree_vec;
  logic [CNT_W-1:0]   agree_sum;
  logic [CNT_W-1:0]   need_k;
  logic [SPARE_W-1:0] spare_fill;
  logic               vote_hit;

  for (genvar i = 0; i < N_BIG; i++) begin : g_act
    assign active[i] = !use_four || (i < N_SMALL);
  end

  corr_agree #(.N(N_BIG)) u_agree (
    .test_bit (test_bit),
    .samples  (samples),
    .active   (active),
    .agree    (agree_vec)
  );

  corr_thresh #(
    .N_BIG(N_BIG), .N_SMALL(N_SMALL), .CNT_W(CNT_W), .SPARE_W(SPARE_W)
  ) u_thresh (
    .use_four   (use_four),
    .code       (thr_code),
    .need_k     (need_k),
    .spare_fill (spare_fill)
  );

  corr_vote #(.W(VOTE_W)) u_vote (
    .votes ({spare_fill, agree_vec}),
    .hit   (vote_hit)
  );

  assign agree_sum = CNT_W'(count_ones(16'(agree_vec)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      match     <= 1'b0;
      agree_cnt <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        match     <= vote_hit;
        agree_cnt <= agree_sum;
      end
    end
  end
endmodule

// File: rtl/corr_detect_chk.sv
module corr_detect_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             use_four,
  input logic [1:0]       thr_code,
  input logic             out_valid,
  input logic             match,
  input logic [CNT_W-1:0] agree_cnt,
  input logic [CNT_W-1:0] agree_sum,
  input logic [CNT_W-1:0] need_k,
  input logic             vote_hit
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !match && agree_cnt == '0));

  // R3
  wide_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_four && thr_code == 2'b00) |=> (match == (agree_cnt >= CNT_W'(3))));

  // R4
  wide_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_four && thr_code == 2'b01) |=> (match == (agree_cnt >= CNT_W'(4))));

  // R5
  wide_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_four && thr_code[1]) |=> (match == (agree_cnt == CNT_W'(5))));

  // R6
  narrow_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && use_four && thr_code == 2'b00) |=> (match == (agree_cnt >= CNT_W'(3))));

  // R7
  narrow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && use_four && thr_code != 2'b00) |=> (match == (agree_cnt == CNT_W'(4))));

  // R8
  narrow_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && use_four) |=> (agree_cnt <= CNT_W'(4)));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(match) && $stable(agree_cnt)));

  // R3 R4 R5 R6 R7: voter and counter paths agree
  vote_vs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vote_hit == (agree_sum >= need_k));
endmodule

bind corr_detect corr_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .use_four  (use_four),
  .thr_code  (thr_code),
  .out_valid (out_valid),
  .match     (match),
  .agree_cnt (agree_cnt),
  .agree_sum (agree_sum),
  .need_k    (need_k),
  .vote_hit  (vote_hit)
);

// File: tb/sim_corr_detect.sv
module sim_corr_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       test_bit = 1'b0;
  logic [4:0] samples = '0;
  logic       use_four = 1'b0;
  logic [1:0] thr_code = 2'b00;
  logic       out_valid;
  logic       match;
  logic [2:0] agree_cnt;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  corr_detect u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .test_bit(test_bit),
    .samples(samples), .use_four(use_four), .thr_code(thr_code),
    .out_valid(out_valid), .match(match), .agree_cnt(agree_cnt)
  );

  // {req[16:13], use_four[12], thr_code[11:10], test_bit[9], samples[8:4], match[3], cnt[2:0]}
  localparam int NV = 17;
  localparam logic [16:0] VEC [NV] = '{
    {4'd3, 1'b0, 2'b00, 1'b1, 5'b10110, 1'b1, 3'd3},  // R3 on threshold
    {4'd3, 1'b0, 2'b00, 1'b0, 5'b10110, 1'b0, 3'd2},  // R3 below, test 0
    {4'd3, 1'b0, 2'b00, 1'b0, 5'b00000, 1'b1, 3'd5},  // R3 R2 all zeros agree
    {4'd4, 1'b0, 2'b01, 1'b1, 5'b11101, 1'b1, 3'd4},  // R4 on threshold
    {4'd4, 1'b0, 2'b01, 1'b1, 5'b10101, 1'b0, 3'd3},  // R4 below
    {4'd4, 1'b0, 2'b01, 1'b0, 5'b01000, 1'b1, 3'd4},  // R4 test 0
    {4'd5, 1'b0, 2'b10, 1'b1, 5'b11111, 1'b1, 3'd5},  // R5 full
    {4'd5, 1'b0, 2'b10, 1'b1, 5'b11011, 1'b0, 3'd4},  // R5 one short
    {4'd5, 1'b0, 2'b11, 1'b0, 5'b00000, 1'b1, 3'd5},  // R5 unused code
    {4'd5, 1'b0, 2'b11, 1'b0, 5'b00001, 1'b0, 3'd4},  // R5 unused code short
    {4'd6, 1'b1, 2'b00, 1'b1, 5'b00111, 1'b1, 3'd3},  // R6 on threshold
    {4'd6, 1'b1, 2'b00, 1'b0, 5'b00011, 1'b0, 3'd2},  // R6 below
    {4'd7, 1'b1, 2'b01, 1'b1, 5'b01111, 1'b1, 3'd4},  // R7 full
    {4'd7, 1'b1, 2'b10, 1'b1, 5'b00111, 1'b0, 3'd3},  // R7 short
    {4'd7, 1'b1, 2'b11, 1'b0, 5'b00000, 1'b1, 3'd4},  // R7 unused code
    {4'd8, 1'b1, 2'b00, 1'b1, 5'b10011, 1'b0, 3'd2},  // R8 top sample set, not counted
    {4'd8, 1'b1, 2'b11, 1'b0, 5'b10000, 1'b1, 3'd4}   // R8 top sample disagrees, ignored
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic f, input logic [1:0] t, input logic tb, input logic [4:0] s);
    @(negedge clk);
    in_valid = 1'b1; use_four = f; thr_code = t; test_bit = tb; samples = s;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "out_valid", int'(out_valid), 0);
    check("R1", "match", int'(match), 0);
    check("R1", "agree_cnt", int'(agree_cnt), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][16:13]);
      apply(VEC[i][12], VEC[i][11:10], VEC[i][9], VEC[i][8:4]);
      check(rq, "match", int'(match), int'(VEC[i][3]));
      check("R2", "agree_cnt", int'(agree_cnt), int'(VEC[i][2:0]));
      check("R9", "out_valid", int'(out_valid), 1);
    end

    // R9: out_valid drops after one cycle
    @(negedge clk);
    check("R9", "out_valid low", int'(out_valid), 0);

    // R10: idle inputs change, outputs hold (last result match=1, cnt=4)
    use_four = 1'b0; thr_code = 2'b00; test_bit = 1'b1; samples = 5'b00000;
    repeat (3) @(negedge clk);
    check("R10", "match held", int'(match), 1);
    check("R10", "agree_cnt held", int'(agree_cnt), 4);

    // R8: narrow mode, toggling only samples[4] leaves results alone
    apply(1'b1, 2'b00, 1'b1, 5'b01110);
    check("R8", "match s4=0", int'(match), 1);
    check("R8", "cnt s4=0", int'(agree_cnt), 3);
    apply(1'b1, 2'b00, 1'b1, 5'b11110);
    check("R8", "match s4=1", int'(match), 1);
    check("R8", "cnt s4=1", int'(agree_cnt), 3);

    // R9: back-to-back requests each update
    @(negedge clk);
    in_valid = 1'b1; use_four = 1'b0; thr_code = 2'b10; test_bit = 1'b1; samples = 5'b11111;
    @(negedge clk);
    check("R9", "first of pair", int'(agree_cnt), 5);
    samples = 5'b00001;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "second of pair cnt", int'(agree_cnt), 1);
    check("R9", "second of pair match", int'(match), 0);

    // R1: reset in mid-run clears outputs
    apply(1'b0, 2'b00, 1'b0, 5'b00000);
    rst_n = 1'b0;
    #1;
    check("R1", "match after reset", int'(match), 0);
    check("R1", "cnt after reset", int'(agree_cnt), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule